// File: doc/BRIEF.md
# Address-Tagged Alias-Checking Register File

This block is a small register file whose entries can each be bound to a word address in memory. A value that might be reached through a pointer can then stay in a register and still give correct results. Every load and store seen on the snoop port is compared against the tags of all bound entries in the same cycle. A hit is handled in one of two ways, chosen by a mode input. In the first, the register answers the access itself. In the second, a trap pulse is raised and the access goes to memory untouched, so the entries also serve as data-address breakpoints.

Each entry has a valid bit and a dirty bit. When a dirty entry is rebound to a new address or released, the block first offers the old address and data on a write-back port with a valid/ready handshake. The command is completed in the cycle that write-back is accepted. Snoop traffic is stalled for the whole wait.

Top module: `alias_tag_regfile`

## Requirements
- R1: After reset every entry is invalid and clean. The write-back port is idle, and no hit, trap or duplicate flag is raised.
- R2: A bind command loads the tag, sets valid and clears dirty. In forward mode (trapMode=0), a snoop load whose full address equals a valid tag sets snHit and returns that entry's data on snRdData in the same cycle, with memPass low.
- R3: An invalid entry never matches, even when its stale tag equals the address. A snoop access that misses every valid entry raises memPass and leaves snHit and trapPulse low.
- R4: In forward mode, a snoop store that hits writes snWrData into the entry and marks it dirty. memPass stays low for that store.
- R5: A register-port write to a valid entry marks it dirty. A register-port write to an invalid entry updates the data but leaves the entry clean.
- R6: A bind or release aimed at a valid dirty entry holds cmdReady low and raises wbValid, carrying the old tag and data. The command completes in the cycle wbReady is high, so an accepted write-back costs one idle cycle plus one cycle per handshake wait cycle plus one.
- R7: A bind or release aimed at a clean or invalid entry completes in the cycle it is presented, with no write-back request.
- R8: While a write-back is pending, snStall is high, and snoop accesses produce no hit, no trap, no memPass and no change of state.
- R9: When several valid entries hold the matching tag, the lowest-numbered one answers, and dupErr is high in that cycle.
- R10: In trap mode (trapMode=1), a hitting access raises trapPulse for that cycle with the hit entry on trapIdx, keeps snHit low and memPass high, and modifies no entry.
- R11: rfRdData shows the data of entry rfRdIdx combinationally. A register write or forwarded store is visible there from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapMode | input | 1 | 0: forward on hit, 1: trap on hit |
| rfWrEn | input | 1 | Register-port write strobe |
| rfWrIdx | input | 3 | Register-port write entry |
| rfWrData | input | 32 | Register-port write data |
| rfRdIdx | input | 3 | Register-port read entry |
| rfRdData | output | 32 | Register-port read data |
| cmdValid | input | 1 | Bind/release command present (held until cmdReady) |
| cmdRelease | input | 1 | 0: bind to cmdAddr, 1: release entry |
| cmdIdx | input | 3 | Entry targeted by the command |
| cmdAddr | input | 32 | Address to bind |
| cmdReady | output | 1 | Command completes this cycle |
| snValid | input | 1 | Snoop access present |
| snWrite | input | 1 | 1: store, 0: load |
| snAddr | input | 32 | Snoop word address |
| snWrData | input | 32 | Store data |
| snStall | output | 1 | Snoop port stalled by a pending write-back |
| snHit | output | 1 | Forwarded hit |
| snRdData | output | 32 | Forwarded load data, zero otherwise |
| memPass | output | 1 | Access must go to memory |
| trapPulse | output | 1 | Trap-mode hit |
| trapIdx | output | 3 | Entry that caused the trap |
| dupErr | output | 1 | More than one valid entry matched |
| wbValid | output | 1 | Write-back request |
| wbReady | input | 1 | Write-back accepted |
| wbAddr | output | 32 | Old tag being written back |
| wbData | output | 32 | Old data being written back |

## Verification
The hardest state to reach is a write-back held open across several cycles while snoop traffic to the entry being evicted keeps arriving. Only then does the stall gating get tested against live hits. The bench reaches it by dirtying an entry through the register port first. It then rebinds that entry with wbReady held low for three cycles and a load to the old address kept on the snoop port. Duplicate tags are produced on purpose by binding a second, higher entry to an address already held. A long random phase then mixes modes, stores and register writes over the bound addresses.

// File: rtl/artf_pkg.sv
package artf_pkg;
  typedef struct packed {
    logic applyCmd;
    logic stall;
  } artfStrobes_t;

  typedef enum logic [0:0] {
    ST_IDLE      = 1'b0,
    ST_WRITEBACK = 1'b1
  } artfState_t;
endpackage

// File: rtl/artf_datapath.sv
module artf_datapath
  import artf_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  artfStrobes_t      strobes,
  input  logic              trapMode,
  input  logic              rfWrEn,
  input  logic [IDX_W-1:0]  rfWrIdx,
  input  logic [DATA_W-1:0] rfWrData,
  input  logic [IDX_W-1:0]  rfRdIdx,
  output logic [DATA_W-1:0] rfRdData,
  input  logic              cmdRelease,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              entryNeedsWb,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData,
  input  logic              snValid,
  input  logic              snWrite,
  input  logic [ADDR_W-1:0] snAddr,
  input  logic [DATA_W-1:0] snWrData,
  output logic              snHit,
  output logic [DATA_W-1:0] snRdData,
  output logic              memPass,
  output logic              trapPulse,
  output logic [IDX_W-1:0]  trapIdx,
  output logic              dupErr
);
  logic [ADDR_W-1:0]      tagQ   [NUM_ENTRIES];
  logic [DATA_W-1:0]      dataQ  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] validQ;
  logic [NUM_ENTRIES-1:0] dirtyQ;
  logic [NUM_ENTRIES-1:0] matchVec;
  logic                   anyMatch;
  logic [IDX_W-1:0]       hitIdx;
  logic                   accessLive;
  logic                   fwdStore;

  // Fully associative compare, one comparator per entry
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = validQ[g] && (tagQ[g] == snAddr);
  end

  // Lowest-numbered matching entry wins
  always_comb begin
    anyMatch = 1'b0;
    hitIdx   = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyMatch = 1'b1;
        hitIdx   = IDX_W'(i);
      end
    end
  end

  assign accessLive = snValid && !strobes.stall;
  assign snHit      = accessLive && anyMatch && !trapMode;
  assign trapPulse  = accessLive && anyMatch && trapMode;
  assign trapIdx    = trapPulse ? hitIdx : '0;
  assign memPass    = accessLive && !snHit;
  assign dupErr     = accessLive && ($countones(matchVec) > 1);
  assign snRdData   = (snHit && !snWrite) ? dataQ[hitIdx] : '0;
  assign fwdStore   = snHit && snWrite;

  assign rfRdData     = dataQ[rfRdIdx];
  assign entryNeedsWb = validQ[cmdIdx] && dirtyQ[cmdIdx];
  assign wbAddr       = tagQ[cmdIdx];
  assign wbData       = dataQ[cmdIdx];

  // Later assignments take priority: command over store over register write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tagQ[i]  <= '0;
        dataQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (rfWrEn && rfWrIdx == IDX_W'(i)) begin
          dataQ[i] <= rfWrData;
          if (validQ[i]) dirtyQ[i] <= 1'b1;
        end
        if (fwdStore && hitIdx == IDX_W'(i)) begin
          dataQ[i]  <= snWrData;
          dirtyQ[i] <= 1'b1;
        end
        if (strobes.applyCmd && cmdIdx == IDX_W'(i)) begin
          tagQ[i]   <= cmdAddr;
          validQ[i] <= !cmdRelease;
          dirtyQ[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/artf_control.sv
module artf_control
  import artf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic         entryNeedsWb,
  input  logic         wbReady,
  output logic         cmdReady,
  output logic         wbValid,
  output artfStrobes_t strobes
);
  artfState_t stateQ, stateD;

  always_comb begin
    stateD           = stateQ;
    cmdReady         = 1'b0;
    wbValid          = 1'b0;
    strobes.stall    = 1'b0;
    strobes.applyCmd = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        cmdReady = cmdValid && !entryNeedsWb;
        if (cmdValid && entryNeedsWb) stateD = ST_WRITEBACK;
      end
      ST_WRITEBACK: begin
        wbValid       = 1'b1;
        strobes.stall = 1'b1;
        cmdReady      = cmdValid && wbReady;
        if (wbReady) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
    strobes.applyCmd = cmdReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/alias_tag_regfile.sv
module alias_tag_regfile
  import artf_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapMode,
  input  logic              rfWrEn,
  input  logic [IDX_W-1:0]  rfWrIdx,
  input  logic [DATA_W-1:0] rfWrData,
  input  logic [IDX_W-1:0]  rfRdIdx,
  output logic [DATA_W-1:0] rfRdData,
  input  logic              cmdValid,
  input  logic              cmdRelease,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdReady,
  input  logic              snValid,
  input  logic              snWrite,
  input  logic [ADDR_W-1:0] snAddr,
  input  logic [DATA_W-1:0] snWrData,
  output logic              snStall,
  output logic              snHit,
  output logic [DATA_W-1:0] snRdData,
  output logic              memPass,
  output logic              trapPulse,
  output logic [IDX_W-1:0]  trapIdx,
  output logic              dupErr,
  output logic              wbValid,
  input  logic              wbReady,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);
  artfStrobes_t strobes;
  logic         entryNeedsWb;

  artf_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .entryNeedsWb (entryNeedsWb),
    .wbReady      (wbReady),
    .cmdReady     (cmdReady),
    .wbValid      (wbValid),
    .strobes      (strobes)
  );

  artf_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .trapMode     (trapMode),
    .rfWrEn       (rfWrEn),
    .rfWrIdx      (rfWrIdx),
    .rfWrData     (rfWrData),
    .rfRdIdx      (rfRdIdx),
    .rfRdData     (rfRdData),
    .cmdRelease   (cmdRelease),
    .cmdIdx       (cmdIdx),
    .cmdAddr      (cmdAddr),
    .entryNeedsWb (entryNeedsWb),
    .wbAddr       (wbAddr),
    .wbData       (wbData),
    .snValid      (snValid),
    .snWrite      (snWrite),
    .snAddr       (snAddr),
    .snWrData     (snWrData),
    .snHit        (snHit),
    .snRdData     (snRdData),
    .memPass      (memPass),
    .trapPulse    (trapPulse),
    .trapIdx      (trapIdx),
    .dupErr       (dupErr)
  );

  assign snStall = strobes.stall;
endmodule

// File: rtl/alias_tag_regfile_checker.sv
module alias_tag_regfile_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              snValid,
  input logic              snStall,
  input logic              snHit,
  input logic              memPass,
  input logic              trapPulse,
  input logic              dupErr,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic              wbValid,
  input logic              wbReady,
  input logic [ADDR_W-1:0] wbAddr
);
  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rstN)
    snStall |-> (!snHit && !trapPulse && !memPass));

  a_r6_wait_holds_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady) |-> !cmdReady);

  a_r6_wb_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady && cmdValid) |=> (wbValid && $stable(wbAddr)));

  a_r10_hit_trap_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({snHit, trapPulse}));

  a_r10_trap_passes: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> memPass);

  a_r2_hit_not_passed: assert property (@(posedge clk) disable iff (!rstN)
    snHit |-> !memPass);

  a_r9_dup_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    dupErr |-> (snHit || trapPulse));

  a_r3_pass_needs_access: assert property (@(posedge clk) disable iff (!rstN)
    memPass |-> snValid);
endmodule

bind alias_tag_regfile alias_tag_regfile_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .snValid   (snValid),
  .snStall   (snStall),
  .snHit     (snHit),
  .memPass   (memPass),
  .trapPulse (trapPulse),
  .dupErr    (dupErr),
  .cmdValid  (cmdValid),
  .cmdReady  (cmdReady),
  .wbValid   (wbValid),
  .wbReady   (wbReady),
  .wbAddr    (wbAddr)
);

// File: tb/tb_alias_tag_regfile.sv
`timescale 1ns/1ps
module tb_alias_tag_regfile;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapMode = 1'b0;
  logic        rfWrEn = 1'b0;
  logic [2:0]  rfWrIdx = '0;
  logic [31:0] rfWrData = '0;
  logic [2:0]  rfRdIdx = '0;
  logic [31:0] rfRdData;
  logic        cmdValid = 1'b0;
  logic        cmdRelease = 1'b0;
  logic [2:0]  cmdIdx = '0;
  logic [31:0] cmdAddr = '0;
  logic        cmdReady;
  logic        snValid = 1'b0;
  logic        snWrite = 1'b0;
  logic [31:0] snAddr = '0;
  logic [31:0] snWrData = '0;
  logic        snStall, snHit, memPass, trapPulse, dupErr, wbValid;
  logic [31:0] snRdData, wbAddr, wbData;
  logic [2:0]  trapIdx;
  logic        wbReady = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  alias_tag_regfile dut (
    .clk(clk), .rstN(rstN), .trapMode(trapMode),
    .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData),
    .rfRdIdx(rfRdIdx), .rfRdData(rfRdData),
    .cmdValid(cmdValid), .cmdRelease(cmdRelease), .cmdIdx(cmdIdx),
    .cmdAddr(cmdAddr), .cmdReady(cmdReady),
    .snValid(snValid), .snWrite(snWrite), .snAddr(snAddr), .snWrData(snWrData),
    .snStall(snStall), .snHit(snHit), .snRdData(snRdData), .memPass(memPass),
    .trapPulse(trapPulse), .trapIdx(trapIdx), .dupErr(dupErr),
    .wbValid(wbValid), .wbReady(wbReady), .wbAddr(wbAddr), .wbData(wbData)
  );

  // Behavioural reference state
  logic [31:0] mTag [NE];
  logic [31:0] mData[NE];
  bit          mVal [NE];
  bit          mDirty[NE];
  bit          mBusy;

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", what, got, exp, $time);
    end
  endtask

  function automatic void lookup(input logic [31:0] a, output int idx, output int cnt);
    idx = 0; cnt = 0;
    for (int i = NE - 1; i >= 0; i--)
      if (mVal[i] && mTag[i] == a) begin idx = i; cnt++; end
  endfunction

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      int  idx, cnt;
      bit  live, fwdHit, trp, needWb;
      lookup(snAddr, idx, cnt);
      live   = snValid && !mBusy;
      fwdHit = live && cnt > 0 && !trapMode;
      trp    = live && cnt > 0 && trapMode;
      needWb = mVal[cmdIdx] && mDirty[cmdIdx];
      chk("R11 rfRdData", rfRdData, mData[rfRdIdx]);
      chk("R2 snHit", {31'b0, snHit}, {31'b0, fwdHit});
      chk("R2 snRdData", snRdData, (fwdHit && !snWrite) ? mData[idx] : 32'h0);
      chk("R3 memPass", {31'b0, memPass}, {31'b0, live && !fwdHit});
      chk("R10 trapPulse", {31'b0, trapPulse}, {31'b0, trp});
      chk("R10 trapIdx", {29'b0, trapIdx}, trp ? 32'(idx) : 32'h0);
      chk("R9 dupErr", {31'b0, dupErr}, {31'b0, live && cnt > 1});
      chk("R8 snStall", {31'b0, snStall}, {31'b0, mBusy});
      chk("R6 wbValid", {31'b0, wbValid}, {31'b0, mBusy});
      chk("R6 cmdReady", {31'b0, cmdReady},
          {31'b0, cmdValid && (mBusy ? wbReady : !needWb)});
      if (mBusy) begin
        chk("R6 wbAddr", wbAddr, mTag[cmdIdx]);
        chk("R6 wbData", wbData, mData[cmdIdx]);
      end
    end
  end

  // Reference state update at the active edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NE; i++) begin
        mTag[i] = '0; mData[i] = '0; mVal[i] = 0; mDirty[i] = 0;
      end
      mBusy = 0;
    end else begin
      int  idx, cnt;
      bit  live, fstore, needWb, apply, nextBusy;
      lookup(snAddr, idx, cnt);
      live     = snValid && !mBusy;
      fstore   = live && cnt > 0 && !trapMode && snWrite;
      needWb   = mVal[cmdIdx] && mDirty[cmdIdx];
      apply    = cmdValid && (mBusy ? wbReady : !needWb);
      nextBusy = mBusy ? !wbReady : (cmdValid && needWb);
      if (rfWrEn) begin
        mData[rfWrIdx] = rfWrData;
        if (mVal[rfWrIdx]) mDirty[rfWrIdx] = 1;
      end
      if (fstore) begin
        mData[idx] = snWrData; mDirty[idx] = 1;
      end
      if (apply) begin
        mTag[cmdIdx] = cmdAddr; mVal[cmdIdx] = !cmdRelease; mDirty[cmdIdx] = 0;
      end
      mBusy = nextBusy;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  logic [31:0] seenWbAddr, seenWbData;

  task automatic doCmd(input bit rel, input int idx, input logic [31:0] addr,
                       input int wbLat, output int cyc);
    bit done;
    cmdValid = 1; cmdRelease = rel; cmdIdx = 3'(idx); cmdAddr = addr;
    cyc = 0; done = 0; seenWbAddr = '0; seenWbData = '0;
    while (!done) begin
      wbReady = (cyc > wbLat);
      @(negedge clk);
      if (wbValid && cyc == 1) begin seenWbAddr = wbAddr; seenWbData = wbData; end
      done = cmdReady;
      step();
      cyc++;
    end
    cmdValid = 0; wbReady = 0;
  endtask

  task automatic rfWrite(input int idx, input logic [31:0] d);
    rfWrEn = 1; rfWrIdx = 3'(idx); rfWrData = d; step(); rfWrEn = 0;
  endtask

  initial begin
    int cyc;
    repeat (3) step();
    rstN = 1;
    @(negedge clk);
    // R1: reset state seen at the ports
    chk("R1 wbValid", {31'b0, wbValid}, 32'h0);
    chk("R1 rfRdData", rfRdData, 32'h0);
    chk("R1 dupErr", {31'b0, dupErr}, 32'h0);
    step();
    // R3: stale tag 0 must not match address 0
    snValid = 1; snWrite = 0; snAddr = 32'h0;
    @(negedge clk);
    chk("R3 invalid no hit", {31'b0, snHit}, 32'h0);
    chk("R3 miss passes", {31'b0, memPass}, 32'h1);
    step(); snValid = 0;

    rfWrite(0, 32'hA5A50000);            // entry 0 still invalid: stays clean (R5)
    doCmd(0, 0, 32'h100, 0, cyc);
    chk("R7 clean bind cycles", 32'(cyc), 32'd1);
    doCmd(0, 1, 32'h104, 0, cyc);
    doCmd(0, 2, 32'h108, 0, cyc);
    doCmd(0, 3, 32'h10C, 0, cyc);
    rfWrite(1, 32'h11111111);
    rfWrite(2, 32'h22222222);
    rfWrite(3, 32'h33333333);

    // R2: forwarded load
    snValid = 1; snWrite = 0; snAddr = 32'h100;
    @(negedge clk);
    chk("R2 load hit", {31'b0, snHit}, 32'h1);
    chk("R2 load data", snRdData, 32'hA5A50000);
    step();
    // R4: forwarded store, then read it back (R11)
    snWrite = 1; snAddr = 32'h108; snWrData = 32'hDEADBEEF;
    @(negedge clk);
    chk("R4 store not passed", {31'b0, memPass}, 32'h0);
    step(); snValid = 0; snWrite = 0; rfRdIdx = 3'd2;
    @(negedge clk);
    chk("R4 store data in reg", rfRdData, 32'hDEADBEEF);
    step();

    // R6/R8: rebind dirty entry 1 with a slow write-back while loads keep coming
    snValid = 1; snAddr = 32'h104;
    doCmd(0, 1, 32'h300, 3, cyc);
    chk("R6 slow wb cycles", 32'(cyc), 32'd5);
    chk("R6 wb old addr", seenWbAddr, 32'h104);
    chk("R5 wb old data", seenWbData, 32'h11111111);
    @(negedge clk);
    chk("R8 old addr misses after rebind", {31'b0, snHit}, 32'h0);
    step(); snValid = 0;

    // R5: entry 0 was written while invalid, so rebinding needs no write-back
    doCmd(0, 0, 32'h400, 0, cyc);
    chk("R5 clean after invalid write", 32'(cyc), 32'd1);
    // R4: release of store-dirtied entry 2
    doCmd(1, 2, 32'h0, 0, cyc);
    chk("R4 release wb cycles", 32'(cyc), 32'd2);
    chk("R4 release wb data", seenWbData, 32'hDEADBEEF);
    snValid = 1; snAddr = 32'h108;
    @(negedge clk);
    chk("R3 released misses", {31'b0, snHit}, 32'h0);
    step(); snValid = 0;

    // R9: duplicate tag on entries 3 and 5
    doCmd(0, 5, 32'h10C, 0, cyc);
    snValid = 1; snAddr = 32'h10C;
    @(negedge clk);
    chk("R9 lowest wins", snRdData, 32'h33333333);
    chk("R9 dup flag", {31'b0, dupErr}, 32'h1);
    step();

    // R10: trap mode store
    trapMode = 1; snWrite = 1; snWrData = 32'h77;
    @(negedge clk);
    chk("R10 trap", {31'b0, trapPulse}, 32'h1);
    chk("R10 trap idx", {29'b0, trapIdx}, 32'h3);
    chk("R10 passes", {31'b0, memPass}, 32'h1);
    step(); snValid = 0; snWrite = 0; trapMode = 0; rfRdIdx = 3'd3;
    @(negedge clk);
    chk("R10 reg untouched", rfRdData, 32'h33333333);
    step();

    // Random mix of snoop traffic, modes and register writes
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      snValid  = $urandom_range(0, 3) != 0;
      snWrite  = $urandom_range(0, 1) == 1;
      snAddr   = (sel < 8) ? 32'h100 + 32'(sel) * 4 : ((sel == 8) ? 32'h300 : $urandom);
      snWrData = $urandom;
      trapMode = $urandom_range(0, 4) == 0;
      rfWrEn   = $urandom_range(0, 3) == 0;
      rfWrIdx  = 3'($urandom_range(0, 7));
      rfWrData = $urandom;
      rfRdIdx  = 3'($urandom_range(0, 7));
      if (n % 100 == 99) begin
        snValid = 0; rfWrEn = 0;
        doCmd($urandom_range(0, 1) == 1, int'($urandom_range(0, 7)),
              32'h100 + 32'($urandom_range(0, 7)) * 4, int'($urandom_range(0, 2)), cyc);
      end else begin
        step();
      end
    end
    snValid = 0; rfWrEn = 0;
    step();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule